// File: doc/BRIEF.md
# UART Interrupt and Receive-Error Status Unit

This block keeps the interrupt and receive-error state of a serial port. Eleven event inputs from the port's transmit, receive and modem logic each set a sticky raw status bit. A mask register selects which raw bits may raise the single combined interrupt line. Software reads the raw and masked views through a small register port and clears raw bits by writing ones to a clear register.

A separate sticky status register collects four receive-error conditions. Its offset serves two purposes: a read returns the error bits, and a write of any value clears them all. The unit also holds the programmable FIFO threshold selections for transmit and receive. It only stores them and drives them out to the FIFO logic, which is outside this block.

Register reads are combinational: `regRdData` reflects the current state during the cycle in which `regRdEn` is high. Writes take effect at the next rising clock edge.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the raw status, mask and error status are all zero, `intrOut` is low, and the threshold register reads 0x12, which means transmit and receive thresholds of 2.
- R2: An event input that is high at a clock edge sets the matching raw bit. The bit can be read at offset 0x03C (bit i for event i) from the following cycle and stays set until it is cleared.
- R3: A write to offset 0x044 clears every raw bit whose data bit is one and leaves every raw bit whose data bit is zero unchanged. Reads of 0x044 return zero.
- R4: When an event arrives in the same cycle as a clear of its bit, the bit ends up set.
- R5: Offset 0x040 reads the raw status ANDed with the mask register.
- R6: `intrOut` is registered. In each cycle it equals the OR of the masked status bits as they stood in the previous cycle.
- R7: Offset 0x038 is a read/write mask of 11 bits at [10:0]. The bits above these read as zero.
- R8: Error inputs set sticky bits in the error status, which is read at offset 0x004 with bit 0 framing, bit 1 parity, bit 2 break and bit 3 overrun.
- R9: Any write to offset 0x004 clears all error bits, whatever the data. An error input that is high in the same cycle as that write leaves its bit set.
- R10: Offset 0x034 holds the transmit threshold in bits [2:0] and the receive threshold in bits [5:3]. Both fields are driven on `txLevel` and `rxLevel`, and the upper bits are ignored on write and read as zero.
- R11: Writes to offsets 0x03C and 0x040 have no effect on any state.
- R12: Reads of unmapped offsets, and any read with `regRdEn` low, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational |
| evtIn | input | 11 | Interrupt event inputs, one per source |
| rxErrIn | input | 4 | Receive error events: framing, parity, break, overrun |
| txLevel | output | 3 | Transmit FIFO threshold selection |
| rxLevel | output | 3 | Receive FIFO threshold selection |
| intrOut | output | 1 | Combined interrupt |

## Verification
The properties assume that the event and error inputs and the register strobes change only between clock edges. They also assume that a write and a read may target the same or different offsets in one cycle without any interaction other than the write landing at the edge. The stimulus drives every input on the falling edge and holds it through the rising edge. It includes cycles where an event coincides with a clear of the same bit, and where an error input coincides with an error-clear write. The reference model handles those cases so that setting wins.

// File: rtl/uart_irq_status_pkg.sv
package uart_irq_status_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ERR  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LVL  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_MIS  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h044;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ERR,
    RD_LVL,
    RD_MASK,
    RD_RAW,
    RD_MIS
  } rdSel_e;

  typedef struct packed {
    logic   errClr;
    logic   lvlWr;
    logic   maskWr;
    logic   intClr;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
  import uart_irq_status_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  always_comb begin
    strb.errClr = regWrEn && (regAddr == OFS_ERR);
    strb.lvlWr  = regWrEn && (regAddr == OFS_LVL);
    strb.maskWr = regWrEn && (regAddr == OFS_MASK);
    strb.intClr = regWrEn && (regAddr == OFS_CLR);
    strb.rdSel  = RD_NONE;
    if (regRdEn) begin
      unique case (regAddr)
        OFS_ERR:  strb.rdSel = RD_ERR;
        OFS_LVL:  strb.rdSel = RD_LVL;
        OFS_MASK: strb.rdSel = RD_MASK;
        OFS_RAW:  strb.rdSel = RD_RAW;
        OFS_MIS:  strb.rdSel = RD_MIS;
        default:  strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_status_regs.sv
module uart_irq_status_regs
  import uart_irq_status_pkg::*;
#(
  parameter int NUM_SRC    = 11,
  parameter int NUM_ERR    = 4,
  parameter int LVL_W      = 3,
  parameter int TX_LVL_RST = 2,
  parameter int RX_LVL_RST = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_ERR-1:0] errIn,
  output logic [NUM_SRC-1:0] rawStat,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [NUM_ERR-1:0] errStat,
  output logic [LVL_W-1:0]   txLvl,
  output logic [LVL_W-1:0]   rxLvl,
  output logic               intrOut,
  output logic [DATA_W-1:0]  rdData
);
  localparam int LVL_TOT = 2 * LVL_W;

  logic [NUM_SRC-1:0] maskedStat;

  // One sticky bit per interrupt source; a set event outranks a clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             rawStat[i] <= 1'b0;
      else if (evtIn[i])                     rawStat[i] <= 1'b1;
      else if (strb.intClr && wrData[i])     rawStat[i] <= 1'b0;
    end
  end

  // Receive error bits: a write of any value clears, new errors still land.
  for (genvar j = 0; j < NUM_ERR; j++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            errStat[j] <= 1'b0;
      else if (errIn[j])    errStat[j] <= 1'b1;
      else if (strb.errClr) errStat[j] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      txLvl   <= LVL_W'(TX_LVL_RST);
      rxLvl   <= LVL_W'(RX_LVL_RST);
      intrOut <= 1'b0;
    end else begin
      if (strb.maskWr) maskReg <= wrData[NUM_SRC-1:0];
      if (strb.lvlWr) begin
        txLvl <= wrData[LVL_W-1:0];
        rxLvl <= wrData[LVL_TOT-1:LVL_W];
      end
      intrOut <= |maskedStat;
    end
  end

  assign maskedStat = rawStat & maskReg;

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_ERR:  rdData[NUM_ERR-1:0] = errStat;
      RD_LVL:  rdData[LVL_TOT-1:0] = {rxLvl, txLvl};
      RD_MASK: rdData[NUM_SRC-1:0] = maskReg;
      RD_RAW:  rdData[NUM_SRC-1:0] = rawStat;
      RD_MIS:  rdData[NUM_SRC-1:0] = maskedStat;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_status_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int NUM_ERR = 4,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_ERR-1:0] rxErrIn,
  output logic [LVL_W-1:0]   txLevel,
  output logic [LVL_W-1:0]   rxLevel,
  output logic               intrOut
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] rawStat;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_ERR-1:0] errStat;

  uart_irq_status_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  uart_irq_status_regs #(
    .NUM_SRC (NUM_SRC),
    .NUM_ERR (NUM_ERR),
    .LVL_W   (LVL_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .evtIn   (evtIn),
    .errIn   (rxErrIn),
    .rawStat (rawStat),
    .maskReg (maskReg),
    .errStat (errStat),
    .txLvl   (txLevel),
    .rxLvl   (rxLevel),
    .intrOut (intrOut),
    .rdData  (regRdData)
  );
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
  import uart_irq_status_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int NUM_ERR = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [NUM_SRC-1:0] evtIn,
  input logic [NUM_ERR-1:0] rxErrIn,
  input logic [NUM_SRC-1:0] rawStat,
  input logic [NUM_SRC-1:0] maskReg,
  input logic [NUM_ERR-1:0] errStat,
  input logic               intrOut
);
  // R2
  raw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((rawStat & $past(evtIn)) == $past(evtIn)));

  // R3
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_CLR)
      |=> ((rawStat & $past(regWrData[NUM_SRC-1:0] & ~evtIn)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_CLR && (evtIn & regWrData[NUM_SRC-1:0]) != '0)
      |=> ((rawStat & $past(evtIn)) == $past(evtIn)));

  // R6
  intr_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    intrOut == $past(|(rawStat & maskReg)));

  // R7
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_MASK) |=> (maskReg == $past(regWrData[NUM_SRC-1:0])));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_ERR) |=> (errStat == $past(rxErrIn)));

  // R11
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && regAddr == OFS_CLR) && evtIn == '0) |=> $stable(rawStat));
endmodule

bind uart_irq_status uart_irq_status_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_ERR (NUM_ERR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evtIn     (evtIn),
  .rxErrIn   (rxErrIn),
  .rawStat   (rawStat),
  .maskReg   (maskReg),
  .errStat   (errStat),
  .intrOut   (intrOut)
);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [10:0] evtIn = '0;
  logic [3:0]  rxErrIn = '0;
  logic [2:0]  txLevel;
  logic [2:0]  rxLevel;
  logic        intrOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  int mRaw = 0, mMask = 0, mErr = 0, mLvl = 'h12;
  bit mIntr = 0;

  always #(CYC/2) clk = ~clk;

  uart_irq_status dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtIn(evtIn), .rxErrIn(rxErrIn), .txLevel(txLevel), .rxLevel(rxLevel),
    .intrOut(intrOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRaw = 0; mMask = 0; mErr = 0; mLvl = 'h12; mIntr = 0;
    end else begin
      mIntr = ((mRaw & mMask) != 0);
      if (regWrEn && regAddr == 12'h044) mRaw = mRaw & ~(regWrData & 'h7FF);
      mRaw = mRaw | evtIn;
      if (regWrEn && regAddr == 12'h004) mErr = 0;
      mErr = mErr | rxErrIn;
      if (regWrEn && regAddr == 12'h038) mMask = regWrData & 'h7FF;
      if (regWrEn && regAddr == 12'h034) mLvl = regWrData & 'h3F;
    end
  end

  function automatic int expRead(input logic [11:0] a);
    case (a)
      12'h004: return mErr;
      12'h034: return mLvl;
      12'h038: return mMask;
      12'h03C: return mRaw;
      12'h040: return mRaw & mMask;
      default: return 0;
    endcase
  endfunction

  function automatic string addrTag(input logic [11:0] a);
    case (a)
      12'h004: return "R8";
      12'h034: return "R10";
      12'h038: return "R7";
      12'h03C: return "R2";
      12'h040: return "R5";
      12'h044: return "R3";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] actual %h expected %h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // One cycle: compare registered outputs, drive inputs, compare read data.
  task automatic cyc(input bit we, input bit re, input logic [11:0] a,
                     input logic [31:0] d, input logic [10:0] ev, input logic [3:0] er);
    @(negedge clk);
    check("R6 intrOut", int'(intrOut), int'(mIntr));
    check("R10 levels", int'({rxLevel, txLevel}), mLvl);
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = d;
    evtIn = ev; rxErrIn = er;
    #1;
    if (re) check(addrTag(a), int'(regRdData), expRead(a));
    else    check("R12 idle read", int'(regRdData), 0);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(0, 1, a, 0, 0, 0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, 0);
  endtask

  initial begin
    #(CYC * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [7] = '{12'h004, 12'h034, 12'h038, 12'h03C, 12'h040, 12'h044, 12'h100};
    #(CYC * 3);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    phase = "R1";
    foreach (addrs[i]) rd(addrs[i]);
    check("R1 reset level", int'({rxLevel, txLevel}), 'h12);
    check("R1 reset intr", int'(intrOut), 0);

    phase = "R7";
    wr(12'h038, 32'hFFFF_F5A5);
    rd(12'h038);

    phase = "R2";
    cyc(0, 1, 12'h03C, 0, 11'h001, 0);
    cyc(0, 1, 12'h03C, 0, 11'h400, 0);
    cyc(0, 1, 12'h03C, 0, 11'h0F0, 0);
    rd(12'h03C);
    phase = "R5";
    rd(12'h040);
    phase = "R6";
    rd(12'h040); rd(12'h040);

    phase = "R3";
    wr(12'h044, 32'h0000_0030);
    rd(12'h03C); rd(12'h044);
    phase = "R4";
    cyc(1, 0, 12'h044, 32'h7FF, 11'h401, 0);
    rd(12'h03C);
    check("R4 set wins", int'(regRdData), 'h401);
    wr(12'h044, 32'h7FF);
    rd(12'h03C);
    check("R3 all cleared", int'(regRdData), 0);
    rd(12'h03C);
    check("R6 intr low after clear", int'(intrOut), 0);

    phase = "R8";
    cyc(0, 1, 12'h004, 0, 0, 4'b0101);
    cyc(0, 1, 12'h004, 0, 0, 4'b1000);
    rd(12'h004);
    phase = "R9";
    wr(12'h004, 32'h0);
    rd(12'h004);
    check("R9 zero data clears", int'(regRdData), 0);
    cyc(0, 0, 0, 0, 0, 4'b0011);
    cyc(1, 0, 12'h004, 32'hFF, 0, 4'b0100);
    rd(12'h004);
    check("R9 error wins", int'(regRdData), 4);

    phase = "R10";
    wr(12'h034, 32'hFFFF_FF2C);
    rd(12'h034);
    check("R10 tx field", int'(txLevel), 4);
    check("R10 rx field", int'(rxLevel), 5);

    phase = "R11";
    cyc(0, 0, 0, 0, 11'h00F, 0);
    wr(12'h03C, 32'h0);
    wr(12'h040, 32'h7FF);
    rd(12'h03C);
    check("R11 raw kept", int'(regRdData), 'h00F);
    rd(12'h040);

    phase = "R12";
    rd(12'h100); rd(12'h008);
    cyc(0, 0, 12'h03C, 0, 0, 0);

    phase = "mixed";
    for (int k = 0; k < 500; k++) begin
      logic [11:0] a = addrs[$urandom % 7];
      logic [10:0] ev = ($urandom % 4 == 0) ? 11'($urandom) : 11'h0;
      logic [3:0]  er = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      cyc(1'($urandom), 1'($urandom), a, $urandom, ev, er);
    end
    cyc(0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule